// File: doc/BRIEF.md
# Setup-Frame Perfect Address Filter

This block holds a table of exact station addresses and uses it to decide, for every received frame, whether the frame is kept or dropped. The table is programmed in-band. The transmit side hands over a fixed 192-byte setup frame as a byte stream, and each byte is tagged by the setup flag of its transmit descriptor. The frame is laid out as 16 slots of 12 bytes. Each slot carries one 48-bit address as three 16-bit pieces, and each piece sits in the two low byte lanes of a 4-byte longword. The filler bytes are all ones, so a slot that nobody programmed holds the broadcast address.

On the receive side the block collects the first six bytes of each frame, which form the destination address. It compares them against all 16 slots in parallel and gives one accept/reject decision per frame. A pass-all-multicast input also accepts any destination whose group bit is set. A new table takes effect only when the last byte of a complete setup frame arrives, and the descriptor then completes with a fixed status word.

Top module: `sf_addr_filter`

## Requirements
- R1: After reset no decision and no completion is signalled, `cfg_status` is zero, and every slot holds the all-ones address, so only the broadcast destination FF:FF:FF:FF:FF:FF is accepted.
- R2: In the setup frame, slot e occupies bytes 12e to 12e+11. Address byte k (k=0 is the first byte on the wire) sits at offset 4*(k/2) + (k%2) within the slot. Byte lanes 2 and 3 of every longword are ignored.
- R3: A frame is accepted when its six destination bytes equal any slot exactly, and rejected otherwise. `dec_valid` is high for exactly the one cycle after the clock edge that takes the sixth byte.
- R4: Each frame gives exactly one decision. Bytes after the sixth have no effect, and a frame shorter than six bytes gives none.
- R5: When `pass_mcast` is 1 at the sixth byte, any destination with bit 0 of its first byte set is accepted. With `pass_mcast` at 0 such a destination needs a table match, and unicast destinations are never affected by `pass_mcast`.
- R6: The table in use stays unchanged until the 192nd byte of a setup frame is taken. A frame decided while loading is in progress uses the old table.
- R7: A byte with `cfg_first` set restarts loading at byte 0. An interrupted partial frame is never committed.
- R8: Bytes presented with `cfg_setup` at 0 are ignored: they neither load nor complete anything.
- R9: `cfg_done` is high for exactly the one cycle after the 192nd byte is taken. In that cycle `cfg_status` is 0x7FFFFFFF (own bit clear); in every other cycle it is 0.
- R10: The all-ones filler makes unused slots match broadcast. Once all 16 slots hold other addresses, broadcast is rejected unless R5 lets it through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_valid | input | 1 | A transmit byte is present |
| cfg_first | input | 1 | The present transmit byte is byte 0 of its frame |
| cfg_setup | input | 1 | The descriptor's setup flag for the present byte |
| cfg_data | input | 8 | Transmit byte |
| cfg_done | output | 1 | One-cycle pulse: setup frame consumed and table replaced |
| cfg_status | output | 32 | Descriptor completion word, valid with `cfg_done` |
| rx_valid | input | 1 | A received byte is present |
| rx_first | input | 1 | The present received byte is byte 0 of its frame |
| rx_data | input | 8 | Received byte |
| pass_mcast | input | 1 | Accept every group-addressed destination |
| dec_valid | output | 1 | One-cycle pulse carrying the frame decision |
| dec_accept | output | 1 | Decision: 1 keeps the frame, 0 drops it |

## Verification
The bench probes the byte-order and lane rules with destinations that differ from a table entry only in the first byte, only in the last byte, or only by two swapped bytes. A design that mixed up the lane layout or compared too few bytes would accept these frames. It loads a setup frame in two halves with receive traffic in between, and it also restarts a load halfway through. A table updated byte by byte, or one committed on an aborted load, would then accept or reject the wrong station. A fully populated table with garbage in the ignored lanes checks the last slot and the loss of broadcast. Frames with trailing bytes, frames that are too short, untagged transmit frames and the multicast override are checked for spurious decisions or table writes.

// File: rtl/sf_filt_pkg.sv
package sf_filt_pkg;
  localparam int ADDR_BYTES  = 6;
  localparam int PIECE_BYTES = 2;
  localparam int WORD_BYTES  = 4;
  localparam int PIECES      = ADDR_BYTES / PIECE_BYTES;
  localparam int SLOT_BYTES  = PIECES * WORD_BYTES;

  // byte k of an address lives at bits [8k+7:8k]; bit 0 is the group bit
  typedef logic [ADDR_BYTES*8-1:0] mac_t;

  localparam logic [31:0] SETUP_DONE_WORD = 32'h7FFF_FFFF;
endpackage

// File: rtl/sf_rst_sync.sv
module sf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/sf_table_loader.sv
module sf_table_loader
  import sf_filt_pkg::*;
#(
  parameter int NUM_ENTRIES = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_valid,
  input  logic                    cfg_first,
  input  logic                    cfg_setup,
  input  logic [7:0]              cfg_data,
  output mac_t [NUM_ENTRIES-1:0]  tbl_o,
  output logic                    done_o,
  output logic [31:0]             status_o
);
  localparam int EW = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam int PW = (PIECES > 1) ? $clog2(PIECES) : 1;
  localparam int LW = $clog2(WORD_BYTES);
  localparam logic [EW-1:0] ENT_LAST = EW'(NUM_ENTRIES - 1);
  localparam logic [PW-1:0] PC_LAST  = PW'(PIECES - 1);
  localparam logic [LW-1:0] LN_LAST  = LW'(WORD_BYTES - 1);
  localparam logic [LW-1:0] LN_KEEP  = LW'(PIECE_BYTES);

  logic [EW-1:0] ent_q, ent_n, ent_cur;
  logic [PW-1:0] pc_q, pc_n, pc_cur;
  logic [LW-1:0] ln_q, ln_n, ln_cur;
  logic          busy_q, busy_n;
  logic          take, step, last, shadow_we;
  int            byte_idx;
  mac_t [NUM_ENTRIES-1:0] shadow_q, shadow_n, tbl_q, tbl_n;
  logic          done_q, done_n;
  logic [31:0]   status_q, status_n;

  always_comb begin
    take     = cfg_valid & cfg_setup;
    step     = take & (cfg_first | busy_q);
    ent_cur  = cfg_first ? '0 : ent_q;
    pc_cur   = cfg_first ? '0 : pc_q;
    ln_cur   = cfg_first ? '0 : ln_q;
    last     = step && (ent_cur == ENT_LAST) && (pc_cur == PC_LAST) && (ln_cur == LN_LAST);
    byte_idx = int'(pc_cur) * PIECE_BYTES + int'(ln_cur);

    shadow_we = step && (ln_cur < LN_KEEP);
    shadow_n  = shadow_q;
    if (shadow_we) shadow_n[ent_cur][byte_idx*8 +: 8] = cfg_data;

    ent_n = ent_q;
    pc_n  = pc_q;
    ln_n  = ln_q;
    if (step) begin
      ent_n = ent_cur;
      pc_n  = pc_cur;
      if (ln_cur == LN_LAST) begin
        ln_n = '0;
        if (pc_cur == PC_LAST) begin
          pc_n  = '0;
          ent_n = ent_cur + EW'(1);
        end else begin
          pc_n = pc_cur + PW'(1);
        end
      end else begin
        ln_n = ln_cur + LW'(1);
      end
    end

    busy_n   = step ? ~last : busy_q;
    tbl_n    = last ? shadow_n : tbl_q;
    done_n   = last;
    status_n = last ? SETUP_DONE_WORD : 32'h0;
  end

  // staging copy: every address byte is rewritten by a full frame before use
  always_ff @(posedge clk) begin
    if (shadow_we) shadow_q <= shadow_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q    <= '0;
      pc_q     <= '0;
      ln_q     <= '0;
      busy_q   <= 1'b0;
      tbl_q    <= '1;
      done_q   <= 1'b0;
      status_q <= 32'h0;
    end else begin
      if (step) begin
        ent_q <= ent_n;
        pc_q  <= pc_n;
        ln_q  <= ln_n;
      end
      busy_q   <= busy_n;
      if (last) tbl_q <= tbl_n;
      done_q   <= done_n;
      status_q <= status_n;
    end
  end

  assign tbl_o    = tbl_q;
  assign done_o   = done_q;
  assign status_o = status_q;
endmodule

// File: rtl/sf_dest_match.sv
module sf_dest_match
  import sf_filt_pkg::*;
#(
  parameter int NUM_ENTRIES = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rx_valid,
  input  logic                    rx_first,
  input  logic [7:0]              rx_data,
  input  logic                    pass_mcast,
  input  mac_t [NUM_ENTRIES-1:0]  tbl_i,
  output logic                    dec_valid_o,
  output logic                    dec_accept_o
);
  localparam int CW = $clog2(ADDR_BYTES + 1);
  localparam logic [CW-1:0] POS_IDLE = CW'(ADDR_BYTES);
  localparam logic [CW-1:0] POS_LAST = CW'(ADDR_BYTES - 1);

  logic [CW-1:0] pos_q, pos_n, pos_cur;
  mac_t          dst_q, dst_n;
  logic          capture, complete, acc_n;
  logic [NUM_ENTRIES-1:0] hit;
  logic          dec_valid_q, dec_valid_n, dec_accept_q, dec_accept_n;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
    assign hit[g] = (tbl_i[g] == dst_n);
  end

  always_comb begin
    pos_cur  = rx_first ? '0 : pos_q;
    capture  = rx_valid & (rx_first | (pos_q != POS_IDLE));
    complete = capture & (pos_cur == POS_LAST);
    dst_n    = dst_q;
    if (capture) dst_n[pos_cur*8 +: 8] = rx_data;
    pos_n    = capture ? pos_cur + CW'(1) : pos_q;
    acc_n    = (|hit) | (pass_mcast & dst_n[0]);
    dec_valid_n  = complete;
    dec_accept_n = complete & acc_n;
  end

  always_ff @(posedge clk) begin
    if (capture) dst_q <= dst_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q        <= POS_IDLE;
      dec_valid_q  <= 1'b0;
      dec_accept_q <= 1'b0;
    end else begin
      if (capture) pos_q <= pos_n;
      dec_valid_q  <= dec_valid_n;
      dec_accept_q <= dec_accept_n;
    end
  end

  assign dec_valid_o  = dec_valid_q;
  assign dec_accept_o = dec_accept_q;
endmodule

// File: rtl/sf_addr_filter.sv
module sf_addr_filter
  import sf_filt_pkg::*;
#(
  parameter int NUM_ENTRIES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_valid,
  input  logic        cfg_first,
  input  logic        cfg_setup,
  input  logic [7:0]  cfg_data,
  output logic        cfg_done,
  output logic [31:0] cfg_status,
  input  logic        rx_valid,
  input  logic        rx_first,
  input  logic [7:0]  rx_data,
  input  logic        pass_mcast,
  output logic        dec_valid,
  output logic        dec_accept
);
  logic                   core_rst_n;
  mac_t [NUM_ENTRIES-1:0] active_tbl;

  sf_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (core_rst_n)
  );

  sf_table_loader #(.NUM_ENTRIES(NUM_ENTRIES)) i_loader (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .cfg_valid (cfg_valid),
    .cfg_first (cfg_first),
    .cfg_setup (cfg_setup),
    .cfg_data  (cfg_data),
    .tbl_o     (active_tbl),
    .done_o    (cfg_done),
    .status_o  (cfg_status)
  );

  sf_dest_match #(.NUM_ENTRIES(NUM_ENTRIES)) i_match (
    .clk          (clk),
    .rst_n        (core_rst_n),
    .rx_valid     (rx_valid),
    .rx_first     (rx_first),
    .rx_data      (rx_data),
    .pass_mcast   (pass_mcast),
    .tbl_i        (active_tbl),
    .dec_valid_o  (dec_valid),
    .dec_accept_o (dec_accept)
  );
endmodule

// File: rtl/sf_addr_filter_chk.sv
module sf_addr_filter_chk #(
  parameter int NUM_ENTRIES = 16,
  parameter int ADDR_BITS   = 48
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          cfg_valid,
  input logic                          cfg_setup,
  input logic                          cfg_done,
  input logic [31:0]                   cfg_status,
  input logic                          rx_valid,
  input logic                          rx_first,
  input logic [7:0]                    rx_data,
  input logic                          pass_mcast,
  input logic                          dec_valid,
  input logic                          dec_accept,
  input logic [NUM_ENTRIES*ADDR_BITS-1:0] tbl
);
  logic grp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    grp_q <= 1'b0;
    else if (rx_valid && rx_first) grp_q <= rx_data[0];
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> !cfg_done); // R9
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |-> $past(cfg_valid && cfg_setup)); // R9
  AST_DONE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |-> (cfg_status == 32'h7FFF_FFFF)); // R9
  AST_DEC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid); // R4
  AST_DEC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(rx_valid)); // R3
  AST_TABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_valid && cfg_setup) |=> $stable(tbl)); // R8
  AST_MCAST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && grp_q && $past(pass_mcast)) |-> dec_accept); // R5
endmodule

bind sf_addr_filter sf_addr_filter_chk #(.NUM_ENTRIES(NUM_ENTRIES)) i_sf_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_valid  (cfg_valid),
  .cfg_setup  (cfg_setup),
  .cfg_done   (cfg_done),
  .cfg_status (cfg_status),
  .rx_valid   (rx_valid),
  .rx_first   (rx_first),
  .rx_data    (rx_data),
  .pass_mcast (pass_mcast),
  .dec_valid  (dec_valid),
  .dec_accept (dec_accept),
  .tbl        (active_tbl)
);

// File: tb/test_sf_addr_filter.sv
`timescale 1ns/1ps
module test_sf_addr_filter;
  logic        clk;
  logic        rst_n;
  logic        cfg_valid, cfg_first, cfg_setup;
  logic [7:0]  cfg_data;
  logic        cfg_done;
  logic [31:0] cfg_status;
  logic        rx_valid, rx_first, pass_mcast;
  logic [7:0]  rx_data;
  logic        dec_valid, dec_accept;

  int n_chk = 0;
  int n_err = 0;

  logic [7:0]  sf [192];
  logic [47:0] tbl_a [16];

  // dest[49:2], pass_mcast[1], expected accept[0]
  localparam logic [49:0] VEC [10] = '{
    {48'h0211_2233_4455, 1'b0, 1'b1},  // R3 entry 0
    {48'h00AA_BBCC_DDEE, 1'b0, 1'b1},  // R3 entry 1
    {48'h0100_5E00_0001, 1'b0, 1'b1},  // R3 group address held in table
    {48'h0211_2233_4456, 1'b0, 1'b0},  // R3 last byte differs
    {48'h0611_2233_4455, 1'b0, 1'b0},  // R3 first byte differs
    {48'hFFFF_FFFF_FFFF, 1'b0, 1'b1},  // R10 filler slots match broadcast
    {48'h0100_5E7F_0009, 1'b0, 1'b0},  // R5 group, override off
    {48'h0100_5E7F_0009, 1'b1, 1'b1},  // R5 group, override on
    {48'h0A0B_0C0D_0E0F, 1'b1, 1'b0},  // R5 unicast unaffected
    {48'h0211_2233_5544, 1'b0, 1'b0}   // R2 swapped bytes
  };

  sf_addr_filter i_sf_addr_filter (
    .clk(clk), .rst_n(rst_n),
    .cfg_valid(cfg_valid), .cfg_first(cfg_first), .cfg_setup(cfg_setup),
    .cfg_data(cfg_data), .cfg_done(cfg_done), .cfg_status(cfg_status),
    .rx_valid(rx_valid), .rx_first(rx_first), .rx_data(rx_data),
    .pass_mcast(pass_mcast), .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string msg, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  // bench-side layout of R2: slot e at 12e, byte k at 4*(k/2)+(k%2)
  task automatic build(input int n, input logic [7:0] gap);
    for (int i = 0; i < 192; i++) sf[i] = 8'hFF;
    for (int e = 0; e < 16; e++)
      for (int w = 0; w < 3; w++) begin
        sf[12*e + 4*w + 2] = gap;
        sf[12*e + 4*w + 3] = gap;
      end
    for (int e = 0; e < n; e++)
      for (int k = 0; k < 6; k++)
        sf[12*e + 4*(k/2) + (k%2)] = tbl_a[e][47-8*k -: 8];
  endtask

  task automatic feed(input int lo, input int hi, input bit tag, input int exp_done);
    int dn = 0;
    for (int i = lo; i < hi; i++) begin
      @(negedge clk);
      if (cfg_done) dn++;
      cfg_valid = 1'b1;
      cfg_setup = tag;
      cfg_first = (i == 0);
      cfg_data  = sf[i];
    end
    @(negedge clk);
    cfg_valid = 1'b0;
    cfg_first = 1'b0;
    if (cfg_done) begin
      dn++;
      chk(cfg_status == 32'h7FFF_FFFF, "R9 completion status", cfg_status, 32'h7FFF_FFFF);
    end
    @(negedge clk);
    if (cfg_done) dn++;
    chk(cfg_status == 32'h0, "R9 status outside completion", cfg_status, 0);
    chk(dn == exp_done, "R7 R8 R9 completion pulse count", dn, exp_done);
  endtask

  task automatic send_rx(input logic [47:0] d, input int len, input bit mc,
                         output int ndec, output bit acc, output int at);
    ndec = 0; acc = 1'b0; at = -1;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (dec_valid) begin ndec++; acc = dec_accept; at = i; end
      rx_valid   = 1'b1;
      rx_first   = (i == 0);
      rx_data    = (i < 6) ? d[47-8*i -: 8] : 8'hFF;
      pass_mcast = mc;
    end
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      rx_valid = 1'b0;
      rx_first = 1'b0;
      if (dec_valid) begin ndec++; acc = dec_accept; at = len + k; end
    end
    pass_mcast = 1'b0;
  endtask

  task automatic rx_expect(input logic [47:0] d, input int len, input bit mc,
                           input bit exp_acc, input string tag);
    int nd; bit ac; int at;
    send_rx(d, len, mc, nd, ac, at);
    chk(nd == 1, {tag, " / R4 one decision"}, nd, 1);
    chk(at == 6, {tag, " / R3 decision timing"}, at, 6);
    chk(ac == exp_acc, tag, ac, exp_acc);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int nd; bit ac; int at;
    cfg_valid = 0; cfg_first = 0; cfg_setup = 0; cfg_data = 0;
    rx_valid = 0; rx_first = 0; rx_data = 0; pass_mcast = 0;
    do_reset();

    // R1 reset state
    chk(cfg_done == 1'b0, "R1 no completion after reset", cfg_done, 0);
    chk(cfg_status == 32'h0, "R1 status zero after reset", cfg_status, 0);
    chk(dec_valid == 1'b0, "R1 no decision after reset", dec_valid, 0);
    rx_expect(48'hFFFF_FFFF_FFFF, 6, 1'b0, 1'b1, "R1 reset table accepts broadcast");
    rx_expect(48'h0211_2233_4455, 6, 1'b0, 1'b0, "R1 reset table rejects unicast");

    // three-entry table, then the vector walk
    tbl_a[0] = 48'h0211_2233_4455;
    tbl_a[1] = 48'h00AA_BBCC_DDEE;
    tbl_a[2] = 48'h0100_5E00_0001;
    build(3, 8'hFF);
    feed(0, 192, 1'b1, 1);
    for (int v = 0; v < 10; v++)
      rx_expect(VEC[v][49:2], 6 + (v % 3) * 5, VEC[v][1], VEC[v][0], "R2 R3 R5 R10 vector");

    // R4 short frame gives no decision, next frame still decided
    send_rx(48'h0211_2233_4455, 4, 1'b0, nd, ac, at);
    chk(nd == 0, "R4 short frame decision count", nd, 0);
    rx_expect(48'h00AA_BBCC_DDEE, 20, 1'b0, 1'b1, "R4 frame after short one");

    // R6 split load: old table in force until the last byte
    tbl_a[0] = 48'h02DE_ADBE_EF01;
    build(1, 8'hFF);
    feed(0, 100, 1'b1, 0);
    rx_expect(48'h0211_2233_4455, 6, 1'b0, 1'b1, "R6 old entry during load");
    rx_expect(48'h02DE_ADBE_EF01, 6, 1'b0, 1'b0, "R6 new entry not yet active");
    feed(100, 192, 1'b1, 1);
    rx_expect(48'h02DE_ADBE_EF01, 6, 1'b0, 1'b1, "R6 new entry after commit");
    rx_expect(48'h0211_2233_4455, 6, 1'b0, 1'b0, "R6 old entry gone after commit");

    // R7 restart discards partial frame
    tbl_a[0] = 48'h02CA_FEF0_0D02;
    build(1, 8'hFF);
    feed(0, 50, 1'b1, 0);
    tbl_a[0] = 48'h0211_2233_4455;
    build(1, 8'hFF);
    feed(0, 192, 1'b1, 1);
    rx_expect(48'h02CA_FEF0_0D02, 6, 1'b0, 1'b0, "R7 aborted entry never loaded");
    rx_expect(48'h0211_2233_4455, 6, 1'b0, 1'b1, "R7 restarted frame loaded");

    // R8 untagged frame ignored
    tbl_a[0] = 48'h0201_0203_0405;
    build(1, 8'hFF);
    feed(0, 192, 1'b0, 0);
    rx_expect(48'h0201_0203_0405, 6, 1'b0, 1'b0, "R8 untagged entry not loaded");
    rx_expect(48'h0211_2233_4455, 6, 1'b0, 1'b1, "R8 table kept");

    // R2 R10 full table, garbage in ignored lanes
    for (int e = 0; e < 16; e++)
      tbl_a[e] = {8'h04, 8'(e), 8'h33, 8'h44, 8'h55, 8'(e*3 + 1)};
    build(16, 8'h5A);
    feed(0, 192, 1'b1, 1);
    rx_expect(tbl_a[15], 6, 1'b0, 1'b1, "R2 last slot");
    rx_expect(tbl_a[0], 9, 1'b0, 1'b1, "R2 first slot, ignored lanes");
    rx_expect(tbl_a[7], 6, 1'b0, 1'b1, "R2 middle slot");
    rx_expect(48'hFFFF_FFFF_FFFF, 6, 1'b0, 1'b0, "R10 broadcast lost with full table");
    rx_expect(48'hFFFF_FFFF_FFFF, 6, 1'b1, 1'b1, "R5 broadcast via group override");

    // R1 reset restores the all-ones table
    do_reset();
    rx_expect(48'hFFFF_FFFF_FFFF, 6, 1'b0, 1'b1, "R1 broadcast after second reset");
    rx_expect(tbl_a[15], 6, 1'b0, 1'b0, "R1 loaded entry cleared by reset");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule